// File: doc/BRIEF.md
# Sample Slip Elastic Buffer

This block decouples a sample producer from a sample consumer that run at the same nominal rate without sharing a clock reference. The producer offers words on a valid/ready stream. The consumer raises a periodic tick and expects exactly one sample back for every tick. Over a long run one side drifts ahead of the other, and the block absorbs the difference by slipping samples. When the producer is too fast, words that arrive into a full store are dropped. When it is too slow, the last sample is repeated. The output cadence therefore follows the consumer's tick and never breaks.

After reset the block fills to half its capacity before it begins to serve stored samples. While it fills, every tick returns zero. When the store runs dry during streaming, the block enters a refill mode. In that mode it repeats the last delivered sample on every tick until the store is half full again. Two saturating counters record the slips, one for repeated ticks and one for discarded words. A mode output shows which of the three phases is active.

The input stream never applies back-pressure: `in_ready` is high whenever the block is out of reset, and overflow is handled by discarding words, not by stalling the producer. The output has no ready signal. The consumer must take `out_data` in the cycle `out_valid` is high, and the value stays unchanged until the next tick is answered. All inputs are single-cycle strobes in the block's clock domain.

Top module: `sample_slip_buffer`

## Requirements
- R1: Accepted words are stored in a circular buffer of DEPTH entries (a power of two) at the write pointer and delivered from the read pointer in arrival order, across pointer wrap-around.
- R2: After reset `mode` is 0 (priming), `out_data` is 0 and both counters are 0. A tick while priming returns 0 and does not count as a slip. `mode` becomes 1 (streaming) in the cycle after the stored count first reaches DEPTH/2.
- R3: Each tick yields `out_valid` high for exactly the next cycle, with the answered sample on `out_data`. Without a tick, `out_valid` is low and `out_data` keeps its value.
- R4: A tick while streaming with an empty store repeats the previous sample and moves `mode` to 2 (refill). Ticks in refill repeat that sample. Refill returns to 1 in the cycle after the stored count reaches DEPTH/2.
- R5: The underrun counter increments once for every tick answered by repetition in streaming or refill mode, including the tick that enters refill.
- R6: A word offered while the store is full and no sample leaves in that cycle is discarded: the stored content is unchanged, later reads never return it, and the overrun counter increments.
- R7: A write and a serviced tick in the same cycle are both carried out and the stored count is unchanged, including when the store is full.
- R8: Both counters are CNT_W bits wide and stay at their maximum value once they reach it.
- R9: `in_ready` is low during reset and high at all other times. `mode` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers `in_data` this cycle |
| in_ready | output | 1 | Block accepts offers (high outside reset) |
| in_data | input | DATA_W | Offered sample |
| tick | input | 1 | Consumer requests one sample |
| out_valid | output | 1 | One-cycle pulse answering a tick |
| out_data | output | DATA_W | Answered sample, held between ticks |
| mode | output | 2 | 0 priming, 1 streaming, 2 refill |
| ovr_cnt | output | CNT_W | Saturating count of discarded words |
| und_cnt | output | CNT_W | Saturating count of repeated ticks |

## Verification
The hardest case to reach from the ports is a full store that also receives a tick and a write in the same cycle. Only that case separates a discarded word from a serviced one. The bench fills the store exactly to capacity, offers two words that must vanish, then issues a simultaneous write and tick. It then drains every entry, so the order of the returned samples shows which words were kept. Saturation uses a narrow counter width, so a few extra underrun ticks and overrun writes drive both counters into their ceiling.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [1:0] {
    SSB_PRIME  = 2'd0,
    SSB_STREAM = 2'd1,
    SSB_REFILL = 2'd2
  } ssb_mode_e;
endpackage

// File: rtl/ssb_ring.sv
module ssb_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] pop_data,
  output logic [$clog2(DEPTH):0] occ,
  output logic              full,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_OCC = (AW+1)'(DEPTH);

  generate
    if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("ssb_ring: DEPTH must be a power of two of at least 2");
    end
  endgenerate

  logic [DATA_W-1:0] store [DEPTH];
  logic [AW:0]       wr_ptr;
  logic [AW:0]       rd_ptr;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign pop_data = store[rd_ptr[AW-1:0]];
  assign occ      = wr_ptr - rd_ptr;
  assign full     = (occ == FULL_OCC);
  assign empty    = (occ == '0);
endmodule

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   wr_req,
  input  logic [$clog2(DEPTH):0] occ,
  input  logic                   full,
  input  logic                   empty,
  output ssb_mode_e              mode,
  output logic                   push,
  output logic                   pop,
  output logic                   ovr_evt,
  output logic                   und_evt
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] HALF_OCC = (AW+1)'(DEPTH / 2);

  ssb_mode_e mode_q;
  ssb_mode_e mode_d;
  logic      primed;

  assign primed  = (occ >= HALF_OCC);
  assign pop     = tick && (mode_q == SSB_STREAM) && !empty;
  assign push    = wr_req && (!full || pop);
  assign ovr_evt = wr_req && full && !pop;
  assign und_evt = tick && ((mode_q == SSB_REFILL) ||
                            ((mode_q == SSB_STREAM) && empty));

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      SSB_PRIME:  if (primed) mode_d = SSB_STREAM;
      SSB_STREAM: if (tick && empty) mode_d = SSB_REFILL;
      SSB_REFILL: if (primed) mode_d = SSB_STREAM;
      default:    mode_d = SSB_PRIME;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= SSB_PRIME;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/ssb_sat_cnt.sv
module ssb_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (inc && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sample_slip_buffer.sv
module sample_slip_buffer
  import ssb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              tick,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        mode,
  output logic [CNT_W-1:0]  ovr_cnt,
  output logic [CNT_W-1:0]  und_cnt
);
  localparam int AW = $clog2(DEPTH);

  logic              rdy_q;
  logic              push;
  logic              pop;
  logic              full;
  logic              empty;
  logic              ovr_evt;
  logic              und_evt;
  logic [AW:0]       occ;
  logic [DATA_W-1:0] pop_data;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  ssb_mode_e         mode_s;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q && rst_n;

  ssb_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_data (in_data),
    .pop_data  (pop_data),
    .occ       (occ),
    .full      (full),
    .empty     (empty)
  );

  ssb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_req  (in_valid && in_ready),
    .occ     (occ),
    .full    (full),
    .empty   (empty),
    .mode    (mode_s),
    .push    (push),
    .pop     (pop),
    .ovr_evt (ovr_evt),
    .und_evt (und_evt)
  );

  ssb_sat_cnt #(.W(CNT_W)) u_ovr_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ovr_evt),
    .cnt   (ovr_cnt)
  );

  ssb_sat_cnt #(.W(CNT_W)) u_und_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (und_evt),
    .cnt   (und_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= tick;
      if (pop) data_q <= pop_data;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign mode      = mode_s;
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              tick,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [1:0]        mode,
  input logic [CNT_W-1:0]  ovr_cnt,
  input logic [CNT_W-1:0]  und_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_TICK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> out_valid); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !out_valid); // R3
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out_data)); // R3
  AST_PRIME_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (out_data == '0)); // R2
  AST_REFILL_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd2) |=> $stable(out_data)); // R4
  AST_UND_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd2 && und_cnt != CMAX) |=> (und_cnt == $past(und_cnt) + 1'b1)); // R5
  AST_UND_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (und_cnt == CMAX) |=> (und_cnt == CMAX)); // R8
  AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_cnt == CMAX) |=> (ovr_cnt == CMAX)); // R8
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3); // R9
  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready); // R9
endmodule

bind sample_slip_buffer ssb_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ssb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .tick      (tick),
  .out_valid (out_valid),
  .out_data  (out_data),
  .mode      (mode),
  .ovr_cnt   (ovr_cnt),
  .und_cnt   (und_cnt)
);

// File: tb/test_sample_slip_buffer.sv
`timescale 1ns/1ps
module test_sample_slip_buffer;
  localparam int DW = 8;
  localparam int DP = 8;
  localparam int CW = 3;
  localparam int NV = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          tick = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [1:0]    mode;
  logic [CW-1:0] ovr_cnt;
  logic [CW-1:0] und_cnt;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sample_slip_buffer #(.DATA_W(DW), .DEPTH(DP), .CNT_W(CW)) i_sample_slip_buffer (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .tick (tick), .out_valid (out_valid), .out_data (out_data),
    .mode (mode), .ovr_cnt (ovr_cnt), .und_cnt (und_cnt)
  );

  // fields: wr, wdata, tick, exp data, exp mode, exp ovr, exp und
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b1, 8'h11, 2'd1, 3'd0, 3'd0},
    {1'b1, 8'h15, 1'b1, 8'h12, 2'd1, 3'd0, 3'd0},
    {1'b0, 8'h00, 1'b1, 8'h13, 2'd1, 3'd0, 3'd0},
    {1'b0, 8'h00, 1'b1, 8'h14, 2'd1, 3'd0, 3'd0},
    {1'b0, 8'h00, 1'b1, 8'h15, 2'd1, 3'd0, 3'd0},
    {1'b0, 8'h00, 1'b1, 8'h15, 2'd2, 3'd0, 3'd1},
    {1'b0, 8'h00, 1'b1, 8'h15, 2'd2, 3'd0, 3'd2},
    {1'b1, 8'h21, 1'b0, 8'h15, 2'd2, 3'd0, 3'd2},
    {1'b1, 8'h22, 1'b0, 8'h15, 2'd2, 3'd0, 3'd2},
    {1'b1, 8'h23, 1'b0, 8'h15, 2'd2, 3'd0, 3'd2},
    {1'b1, 8'h24, 1'b0, 8'h15, 2'd2, 3'd0, 3'd2},
    {1'b0, 8'h00, 1'b0, 8'h15, 2'd1, 3'd0, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h21, 2'd1, 3'd0, 3'd2},
    {1'b1, 8'h25, 1'b0, 8'h21, 2'd1, 3'd0, 3'd2},
    {1'b1, 8'h26, 1'b0, 8'h21, 2'd1, 3'd0, 3'd2},
    {1'b1, 8'h27, 1'b0, 8'h21, 2'd1, 3'd0, 3'd2},
    {1'b1, 8'h28, 1'b0, 8'h21, 2'd1, 3'd0, 3'd2},
    {1'b1, 8'h29, 1'b0, 8'h21, 2'd1, 3'd0, 3'd2},
    {1'b1, 8'h2A, 1'b0, 8'h21, 2'd1, 3'd1, 3'd2},
    {1'b1, 8'h2B, 1'b0, 8'h21, 2'd1, 3'd2, 3'd2},
    {1'b1, 8'h2C, 1'b1, 8'h22, 2'd1, 3'd2, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h23, 2'd1, 3'd2, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h24, 2'd1, 3'd2, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h25, 2'd1, 3'd2, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h26, 2'd1, 3'd2, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h27, 2'd1, 3'd2, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h28, 2'd1, 3'd2, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h29, 2'd1, 3'd2, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h2C, 2'd1, 3'd2, 3'd2},
    {1'b0, 8'h00, 1'b1, 8'h2C, 2'd2, 3'd2, 3'd3}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one cycle at a falling edge; outputs are read at the next falling edge
  task automatic step(input bit wr, input logic [DW-1:0] wd, input bit tk);
    in_valid = wr;
    in_data  = wd;
    tick     = tk;
    @(negedge clk);
    in_valid = 1'b0;
    tick     = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "reset mode", int'(mode), 0);
    check("R2", "reset data", int'(out_data), 0);
    check("R2", "reset ovr", int'(ovr_cnt), 0);
    check("R2", "reset und", int'(und_cnt), 0);
    check("R9", "in_ready after reset", int'(in_ready), 1);

    step(1'b0, '0, 1'b1);
    check("R3", "prime tick valid", int'(out_valid), 1);
    check("R2", "prime tick data", int'(out_data), 0);
    check("R2", "prime tick not a slip", int'(und_cnt), 0);
    step(1'b0, '0, 1'b0);
    check("R3", "valid is one cycle", int'(out_valid), 0);

    step(1'b1, 8'h11, 1'b0);
    step(1'b1, 8'h12, 1'b0);
    step(1'b1, 8'h13, 1'b0);
    check("R2", "below half still priming", int'(mode), 0);
    step(1'b1, 8'h14, 1'b0);
    check("R2", "mode lags count by a cycle", int'(mode), 0);
    step(1'b0, '0, 1'b0);
    check("R2", "streaming at half", int'(mode), 1);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      step(v[25], v[24:17], v[16]);
      check((v[25] && v[16]) ? "R7" : "R1", $sformatf("vec %0d data", i), int'(out_data), int'(v[15:8]));
      check("R3", $sformatf("vec %0d valid", i), int'(out_valid), int'(v[16]));
      check("R4", $sformatf("vec %0d mode", i), int'(mode), int'(v[7:6]));
      check("R6", $sformatf("vec %0d ovr", i), int'(ovr_cnt), int'(v[5:3]));
      check("R5", $sformatf("vec %0d und", i), int'(und_cnt), int'(v[2:0]));
    end

    for (int k = 0; k < 6; k++) step(1'b0, '0, 1'b1);
    check("R8", "und saturates", int'(und_cnt), 7);
    check("R4", "refill keeps repeating", int'(out_data), 8'h2C);

    for (int k = 0; k < DP; k++) step(1'b1, DW'(8'h31 + k), 1'b0);
    step(1'b0, '0, 1'b0);
    check("R4", "refill back to streaming", int'(mode), 1);
    for (int k = 0; k < 10; k++) step(1'b1, 8'hEE, 1'b0);
    check("R8", "ovr saturates", int'(ovr_cnt), 7);
    step(1'b0, '0, 1'b1);
    check("R6", "dropped words absent, oldest first", int'(out_data), 8'h31);
    for (int k = 1; k < DP; k++) step(1'b0, '0, 1'b1);
    check("R1", "last stored after wrap", int'(out_data), 8'h38);
    check("R8", "und held at max", int'(und_cnt), 7);

    done = 1'b1;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule